// File: doc/BRIEF.md
# Coarse/Fine DAC Carry-Transfer Sequencer

This block drives a pair of DACs whose outputs are summed: a coarse DAC carrying the high-order code and a fine DAC carrying the low-order code. The block accepts one-step up and down commands. When the fine code can absorb the step, the block applies it at once and the analog output stage keeps tracking. When the fine code would wrap, the step has to move into the coarse code. The coarse DAC is not exact, so a plain carry could leave the summed level unchanged or make it fall.

In that case the block puts the output stage into hold, which freezes the analog level to be matched. It steps the coarse code and clears the fine code. It then rebuilds the fine code one bit at a time, from its top bit down, against an external comparator that reports whether the DAC sum is above the held level. Each trial bit is given a programmable settling time before the comparator is read. When the last bit has been decided, the output stage returns to track mode. Commands that arrive during a sequence are refused with a one-cycle error pulse.

Top module: `dac_carry_seq`

## Requirements
- R1: After reset both codes are zero, and hold_o, busy_o and reject_o are low.
- R2: An up command with the fine code below all-ones adds one to the fine code on the next clock edge. A down command with the fine code above zero subtracts one. In both cases the coarse code is unchanged and hold_o and busy_o stay low.
- R3: An up command with the fine code at all-ones and the coarse code below all-ones starts a transfer on the next clock edge: the coarse code gains one, the fine code becomes zero, and hold_o and busy_o rise. A down command with the fine code at zero and the coarse code above zero does the same, except that the coarse code loses one.
- R4: During a transfer the coarse code does not change. Fine-code bits are tried from the top bit down. Each trial bit is set, and it is cleared again when cmp_above_i is 1 (DAC sum above the held level) at the sampling edge. If the comparator is monotonic in the fine code, the result is the largest fine code for which it reports not-above.
- R5: Each trial bit is held for settle_cycles_i + 1 cycles before the comparator is sampled. A whole transfer keeps busy_o high for LO_W*(settle_cycles_i+2)+1 cycles.
- R6: When the last bit has been decided, hold_o and busy_o fall on the same edge and the block is back in track mode.
- R7: An up or down command that is present while busy_o is high produces reject_o high for one cycle on the next edge. This includes the final busy cycle. Such a command leaves both codes untouched. A command given once busy_o is low is accepted.
- R8: Up and down given together while not busy are ignored: codes unchanged, no transfer, no reject.
- R9: An up command at coarse and fine all-ones, or a down command at both codes zero, is ignored: codes unchanged, no transfer, no reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_i | input | 1 | Step-up command |
| dec_i | input | 1 | Step-down command |
| settle_cycles_i | input | SETTLE_W | Extra settling cycles per trial bit |
| cmp_above_i | input | 1 | Comparator: DAC sum above held level |
| hi_code_o | output | HI_W | Coarse DAC code |
| lo_code_o | output | LO_W | Fine DAC code |
| hold_o | output | 1 | Output stage hold (1) / track (0) |
| busy_o | output | 1 | Transfer sequence in progress |
| reject_o | output | 1 | One-cycle pulse for a refused command |

## Verification
The end of a transfer and a new step command can fall in the same cycle. On the last busy cycle the sequence is taking its final decision and returning to track, and a command may be present at the same time. The bench provokes this by raising a step command exactly on the final cycle in which busy_o is high. It expects a reject pulse on the next edge, busy_o already low, a correctly decided fine code, and coarse and fine codes that the command did not change. A command one cycle later must then be accepted normally. The same rejection is also provoked in the middle of the bit trials.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {
    S_IDLE,
    S_SET,
    S_WAIT,
    S_DONE
  } seq_state_e;
endpackage

// File: rtl/dcs_step_decode.sv
module dcs_step_decode #(
  parameter int HI_W = 8,
  parameter int LO_W = 8
) (
  input  logic            inc_i,
  input  logic            dec_i,
  input  logic            idle_i,
  input  logic [HI_W-1:0] hi_i,
  input  logic [LO_W-1:0] lo_i,
  output logic            dir_up_o,
  output logic            dir_dn_o,
  output logic            xfer_up_o,
  output logic            xfer_dn_o,
  output logic            reject_o
);
  localparam logic [HI_W-1:0] HI_MAX = '1;
  localparam logic [LO_W-1:0] LO_MAX = '1;

  logic up, dn, lo_full, lo_empty;

  always_comb begin
    up        = idle_i && inc_i && !dec_i;
    dn        = idle_i && dec_i && !inc_i;
    lo_full   = (lo_i == LO_MAX);
    lo_empty  = (lo_i == '0);
    dir_up_o  = up && !lo_full;
    dir_dn_o  = dn && !lo_empty;
    xfer_up_o = up && lo_full && (hi_i != HI_MAX);
    xfer_dn_o = dn && lo_empty && (hi_i != '0);
    reject_o  = !idle_i && (inc_i || dec_i);
  end
endmodule

// File: rtl/dcs_settle_timer.sv
module dcs_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0) && !load_i;
endmodule

// File: rtl/dcs_sar_core.sv
module dcs_sar_core
  import dcs_pkg::*;
#(
  parameter int HI_W = 8,
  parameter int LO_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dir_up_i,
  input  logic            dir_dn_i,
  input  logic            xfer_up_i,
  input  logic            xfer_dn_i,
  input  logic            settled_i,
  input  logic            cmp_above_i,
  output logic [HI_W-1:0] hi_code_o,
  output logic [LO_W-1:0] lo_code_o,
  output seq_state_e      state_o,
  output logic            load_timer_o
);
  localparam int IDX_W = (LO_W > 1) ? $clog2(LO_W) : 1;
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(LO_W - 1);

  seq_state_e      state_q;
  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      hi_q    <= '0;
      lo_q    <= '0;
      idx_q   <= IDX_TOP;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (dir_up_i)      lo_q <= lo_q + 1'b1;
          else if (dir_dn_i) lo_q <= lo_q - 1'b1;
          else if (xfer_up_i || xfer_dn_i) begin
            hi_q    <= xfer_up_i ? hi_q + 1'b1 : hi_q - 1'b1;
            lo_q    <= '0;
            idx_q   <= IDX_TOP;
            state_q <= S_SET;
          end
        end
        S_SET: begin
          lo_q[idx_q] <= 1'b1;
          state_q     <= S_WAIT;
        end
        S_WAIT: begin
          if (settled_i) begin
            if (cmp_above_i) lo_q[idx_q] <= 1'b0;
            if (idx_q == '0) state_q <= S_DONE;
            else begin
              idx_q   <= idx_q - 1'b1;
              state_q <= S_SET;
            end
          end
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign hi_code_o    = hi_q;
  assign lo_code_o    = lo_q;
  assign state_o      = state_q;
  assign load_timer_o = (state_q == S_SET);

  assert_direct_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_up_i |=> (lo_q == LO_W'($past(lo_q) + 1'b1)) && $stable(hi_q));
  assert_direct_dn_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_dn_i |=> (lo_q == LO_W'($past(lo_q) - 1'b1)) && $stable(hi_q));
  assert_xfer_up_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_up_i |=> (hi_q == HI_W'($past(hi_q) + 1'b1)) && (lo_q == '0) && (state_q == S_SET));
  assert_xfer_dn_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_dn_i |=> (hi_q == HI_W'($past(hi_q) - 1'b1)) && (lo_q == '0) && (state_q == S_SET));
  assert_hi_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |=> $stable(hi_q));
  assert_settle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && !settled_i) |=> $stable(lo_q) && (state_q == S_WAIT));
endmodule

// File: rtl/dac_carry_seq.sv
module dac_carry_seq
  import dcs_pkg::*;
#(
  parameter int HI_W     = 8,
  parameter int LO_W     = 8,
  parameter int SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                inc_i,
  input  logic                dec_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic                cmp_above_i,
  output logic [HI_W-1:0]     hi_code_o,
  output logic [LO_W-1:0]     lo_code_o,
  output logic                hold_o,
  output logic                busy_o,
  output logic                reject_o
);
  localparam logic [HI_W-1:0] HI_MAX = '1;
  localparam logic [LO_W-1:0] LO_MAX = '1;

  seq_state_e state;
  logic idle, dir_up, dir_dn, xfer_up, xfer_dn, rej_req;
  logic load_timer, settled, reject_q;

  assign idle = (state == S_IDLE);

  dcs_step_decode #(.HI_W(HI_W), .LO_W(LO_W)) u_decode (
    .inc_i    (inc_i),
    .dec_i    (dec_i),
    .idle_i   (idle),
    .hi_i     (hi_code_o),
    .lo_i     (lo_code_o),
    .dir_up_o (dir_up),
    .dir_dn_o (dir_dn),
    .xfer_up_o(xfer_up),
    .xfer_dn_o(xfer_dn),
    .reject_o (rej_req)
  );

  dcs_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_timer),
    .load_val_i(settle_cycles_i),
    .done_o    (settled)
  );

  dcs_sar_core #(.HI_W(HI_W), .LO_W(LO_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dir_up_i    (dir_up),
    .dir_dn_i    (dir_dn),
    .xfer_up_i   (xfer_up),
    .xfer_dn_i   (xfer_dn),
    .settled_i   (settled),
    .cmp_above_i (cmp_above_i),
    .hi_code_o   (hi_code_o),
    .lo_code_o   (lo_code_o),
    .state_o     (state),
    .load_timer_o(load_timer)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reject_q <= 1'b0;
    else         reject_q <= rej_req;
  end

  assign hold_o   = !idle;
  assign busy_o   = !idle;
  assign reject_o = reject_q;

  assert_ignore_both_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && inc_i && dec_i) |=> $stable(hi_code_o) && $stable(lo_code_o) && !busy_o && !reject_o);
  assert_saturate_top_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && inc_i && !dec_i && hi_code_o == HI_MAX && lo_code_o == LO_MAX)
      |=> $stable(hi_code_o) && $stable(lo_code_o) && !busy_o);
  assert_saturate_bottom_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && dec_i && !inc_i && hi_code_o == '0 && lo_code_o == '0)
      |=> $stable(hi_code_o) && $stable(lo_code_o) && !busy_o);
  assert_reject_untouched_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reject_o && busy_o) |-> $stable(hi_code_o));
endmodule

// File: tb/dac_carry_seq_tb.sv
`timescale 1ns/1ps
module dac_carry_seq_tb;
  localparam int HW = 4;
  localparam int LW = 4;
  localparam int SW = 4;
  localparam int HMAX = (1 << HW) - 1;
  localparam int LMAX = (1 << LW) - 1;

  // vector: {op[1:0] (1 up, 2 down, 3 both), settle[3:0], repeat[5:0]}
  localparam int NV = 7;
  localparam logic [11:0] VEC [NV] = '{
    {2'd1, 4'd0, 6'd15},
    {2'd1, 4'd0, 6'd1},
    {2'd1, 4'd2, 6'd3},
    {2'd2, 4'd1, 6'd20},
    {2'd3, 4'd0, 6'd2},
    {2'd1, 4'd3, 6'd20},
    {2'd2, 4'd0, 6'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inc = 1'b0, dec = 1'b0;
  logic [SW-1:0] settle = '0;
  logic cmp_above;
  logic [HW-1:0] hi_code;
  logic [LW-1:0] lo_code;
  logic hold, busy, reject;

  int total = 0, fails = 0, held = 0, hi_m = 0, lo_m = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic int lvl(int h, int l);
    return h * (LMAX + 1) + ((h * 3) % 5) - 2 + l;
  endfunction

  function automatic int best_lo(int h, int tgt);
    int b = 0;
    for (int l = 0; l <= LMAX; l++) if (lvl(h, l) <= tgt) b = l;
    return b;
  endfunction

  assign cmp_above = lvl(int'(hi_code), int'(lo_code)) > held;

  dac_carry_seq #(.HI_W(HW), .LO_W(LW), .SETTLE_W(SW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .inc_i(inc), .dec_i(dec),
    .settle_cycles_i(settle), .cmp_above_i(cmp_above),
    .hi_code_o(hi_code), .lo_code_o(lo_code),
    .hold_o(hold), .busy_o(busy), .reject_o(reject)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // issue a command at a negedge; model decides direct / transfer / ignore
  task automatic do_step(logic [1:0] op, int s);
    bit xfer = 0;
    int old;
    string tag;
    @(negedge clk);
    settle = SW'(s);
    inc = op[0];
    dec = op[1];
    old = lvl(hi_m, lo_m);
    tag = (op == 2'd3) ? "R8" : "R9";
    if (op == 2'd1) begin
      if (lo_m < LMAX) begin lo_m++; tag = "R2"; end
      else if (hi_m < HMAX) begin xfer = 1; held = old + 1; hi_m++; end
    end else if (op == 2'd2) begin
      if (lo_m > 0) begin lo_m--; tag = "R2"; end
      else if (hi_m > 0) begin xfer = 1; held = old - 1; hi_m--; end
    end
    @(negedge clk);
    inc = 1'b0;
    dec = 1'b0;
    if (!xfer) begin
      chk(lo_code == LW'(lo_m), tag, lo_code, lo_m);
      chk(hi_code == HW'(hi_m), tag, hi_code, hi_m);
      chk(!busy && !hold && !reject, tag, {busy, hold, reject}, 0);
    end else begin
      int cnt = 1;
      chk(busy && hold, "R3", {busy, hold}, 3);
      chk(hi_code == HW'(hi_m) && lo_code == '0, "R3", {hi_code, lo_code}, hi_m << LW);
      while (busy && cnt < 2000) begin @(negedge clk); if (busy) cnt++; end
      chk(cnt == LW * (s + 2) + 1, "R5", cnt, LW * (s + 2) + 1);
      chk(!hold && !busy, "R6", {hold, busy}, 0);
      lo_m = best_lo(hi_m, held);
      chk(lo_code == LW'(lo_m), "R4", lo_code, lo_m);
      chk(hi_code == HW'(hi_m), "R4", hi_code, hi_m);
      if (op == 2'd1) chk(lvl(hi_m, lo_m) > old, "R4", lvl(hi_m, lo_m), old + 1);
      else            chk(lvl(hi_m, lo_m) < old, "R4", lvl(hi_m, lo_m), old - 1);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(hi_code == '0 && lo_code == '0, "R1", {hi_code, lo_code}, 0);
    chk(!hold && !busy && !reject, "R1", {hold, busy, reject}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_step(2'd2, 0);  // R9: down at zero ignored

    for (int i = 0; i < NV; i++)
      for (int r = 0; r < int'(VEC[i][5:0]); r++)
        do_step(VEC[i][11:10], int'(VEC[i][9:6]));

    // R7: rejection mid-sequence and on the final busy cycle
    while (lo_m < LMAX) do_step(2'd1, 0);
    begin
      int old = lvl(hi_m, lo_m);
      int tb_t = LW * 2 + 1;
      @(negedge clk);
      settle = '0;
      inc = 1'b1;
      held = old + 1;
      hi_m++;
      @(negedge clk);
      inc = 1'b0;
      for (int c = 1; c <= tb_t; c++) begin
        chk(busy, "R5", busy, 1);
        if (c == 5 || c == tb_t) begin
          if (c == 5) dec = 1'b1; else inc = 1'b1;
          @(negedge clk);
          inc = 1'b0;
          dec = 1'b0;
          chk(reject, "R7", reject, 1);
          chk(hi_code == HW'(hi_m), "R7", hi_code, hi_m);
          if (c == tb_t) chk(!busy, "R7", busy, 0);
        end else begin
          @(negedge clk);
        end
      end
      lo_m = best_lo(hi_m, held);
      chk(lo_code == LW'(lo_m), "R7", lo_code, lo_m);
      @(negedge clk);
      chk(!reject, "R7", reject, 0);
    end
    do_step(2'd2, 0);  // accepted after busy falls (R7)

    // R9: climb to full scale, then one more up is ignored
    for (int k = 0; k < 400 && !(hi_m == HMAX && lo_m == LMAX); k++) do_step(2'd1, 0);
    chk(hi_m == HMAX && lo_m == LMAX, "R9", hi_m, HMAX);
    do_step(2'd1, 0);
    do_step(2'd3, 1);  // R8 at full scale

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule